// File: doc/BRIEF.md
# Slot-Decoded FPGA Configuration Port

This block is a byte-wide slave on a 24-bit address bus that lets a crate controller load bitstreams into four FPGAs on one card. The card recognises its own configuration window by comparing the geographic slot number, read from the backplane, against five address bits. These bits are wired in a rotated order, not straight across. Within the window, two address bits pick one of four byte ports. Three of them are write-only and drive the FPGA programming pins: the program and chip-select strobes, a configuration data byte, and a control nibble with the configuration clock, the read/write select and a user-logic reset. The fourth is read-only and returns the busy, done and init status lines.

The bus handshake is a level strobe with an acknowledge. The controller holds the address, data and direction stable, raises the strobe, waits for the acknowledge, then drops the strobe. Each strobe performs exactly one access. Software toggles the configuration clock and writes data bytes one access at a time to step through the configuration sequence.

Top module: `cfgp_slave`

## Requirements
- R1: A strobe matches only when address bits 22:21 are 2'b11 and address bits 16, 17, 18, 19, 20 equal slot ID bits 3, 4, 0, 1, 2 respectively. Address bit 23 is ignored. A strobe that does not match gets no acknowledge and changes no output.
- R2: When the slot ID is 1, no address ever matches.
- R3: Address bits 15:14 select the port: 0 = program/select, 1 = data byte, 2 = control, 3 = status. Address bits 13:0 have no effect.
- R4: A write to the program/select port drives data bits 3:0 onto the active-low program strobes of FPGAs 0..3 and bits 7:4 onto their active-low chip selects.
- R5: A write to the data byte port drives all 8 data bits onto the configuration data output.
- R6: A write to the control port sets the configuration clock from bit 0, the read/write-bar select from bit 1 and the user-logic reset from bit 2. Bits 7:3 are ignored.
- R7: A read of the status port returns busy in bit 0, done in bit 1 and init-bar in bit 2, with bits 7:3 zero. The status lines are sampled at the edge that raises the acknowledge.
- R8: A write to the status port changes no output. A read of any write-only port returns zero and changes no output.
- R9: After reset, the program strobes and chip selects are all 1, the data byte, clock, read/write select and user reset are 0, and the acknowledge is low.
- R10: The acknowledge rises on the first clock edge after a matching strobe is seen. It stays high while the strobe stays high, and it falls on the first edge after the strobe drops. Read data is zero whenever the acknowledge is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_id | input | 5 | Geographic slot number of the card |
| bus_addr | input | 24 | Bus address |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data byte |
| bus_strobe | input | 1 | Access request, held until acknowledged |
| bus_ack | output | 1 | Access acknowledge |
| bus_rdata | output | 8 | Read data, valid while acknowledge is high |
| fpga_prog_n | output | 4 | Active-low program strobes, one per FPGA |
| fpga_cs_n | output | 4 | Active-low chip selects, one per FPGA |
| cfg_byte | output | 8 | Configuration data byte |
| cfg_clk | output | 1 | Configuration clock |
| cfg_rdwr_n | output | 1 | Configuration read/write-bar select |
| user_rst | output | 1 | Reset to FPGA user logic |
| fpga_busy | input | 1 | FPGA busy status |
| fpga_done | input | 1 | FPGA done status |
| fpga_init_n | input | 1 | FPGA init-bar status |

## Verification
A wrong bit in the slot comparison shows up as a missing acknowledge or a stray one. The bench therefore sweeps every legal slot and puts a deliberately wrong address and the reserved slot through the same path. A corrupt output register shows on the pins at the negative edge right after the acknowledging edge, because the port registers drive the pins directly. A handshake state that sticks shows as an acknowledge that stays high one cycle after the strobe falls, or that appears for a non-matching strobe. Alias and A23 cases are checked by comparing pin values after accesses at very different low address bits.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        PORT_PROG = 2'd0,
        PORT_DATA = 2'd1,
        PORT_CTRL = 2'd2,
        PORT_STAT = 2'd3
    } port_e;

    // Slot ID bit that is compared with the i-th address bit of the slot field.
    function automatic int slot_src(input int i, input int rot, input int width);
        return (i + rot) % width;
    endfunction

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
    parameter int ADDR_W   = 24,
    parameter int SLOT_W   = 5,
    parameter int SLOT_LSB = 16,
    parameter int SLOT_ROT = 3,
    parameter int WIN_LSB  = 21,
    parameter int WIN_W    = 2,
    parameter logic [WIN_W-1:0] WIN_TAG = '1,
    parameter int SEL_LSB  = 14,
    parameter int RSV_SLOT = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [SLOT_W-1:0] slot_id,
    output logic              hit,
    output cfgp_pkg::port_e   port
);
    localparam logic [SLOT_W-1:0] RSV = SLOT_W'(RSV_SLOT);

    logic [SLOT_W-1:0] slot_eq;

    for (genvar i = 0; i < SLOT_W; i++) begin : g_slot
        localparam int SRC = cfgp_pkg::slot_src(i, SLOT_ROT, SLOT_W);
        assign slot_eq[i] = (addr[SLOT_LSB+i] == slot_id[SRC]);
    end

    logic win_ok;
    logic slot_ok;

    always_comb begin
        win_ok  = (addr[WIN_LSB +: WIN_W] == WIN_TAG);
        slot_ok = (&slot_eq) && (slot_id != RSV);
        hit     = win_ok && slot_ok;
        port    = cfgp_pkg::port_e'(addr[SEL_LSB +: 2]);
    end

endmodule

// File: rtl/cfgp_readback.sv
module cfgp_readback #(
    parameter int DATA_W = 8
) (
    input  cfgp_pkg::port_e    port,
    input  logic               busy,
    input  logic               done,
    input  logic               init_n,
    output logic [DATA_W-1:0]  rval
);
    always_comb begin
        rval = '0;
        if (port == cfgp_pkg::PORT_STAT) begin
            rval[0] = busy;
            rval[1] = done;
            rval[2] = init_n;
        end
    end
endmodule

// File: rtl/cfgp_outregs.sv
module cfgp_outregs #(
    parameter int DATA_W   = 8,
    parameter int NUM_FPGA = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  cfgp_pkg::port_e     port,
    input  logic [DATA_W-1:0]   wdata,
    output logic [NUM_FPGA-1:0] prog_n,
    output logic [NUM_FPGA-1:0] cs_n,
    output logic [DATA_W-1:0]   cfg_byte,
    output logic                cfg_clk,
    output logic                cfg_rdwr_n,
    output logic                user_rst
);
    typedef struct packed {
        logic [NUM_FPGA-1:0] prog_n;
        logic [NUM_FPGA-1:0] cs_n;
        logic [DATA_W-1:0]   data;
        logic                cclk;
        logic                rdwr_n;
        logic                urst;
    } oreg_t;

    localparam oreg_t RST_VAL = '{prog_n: '1, cs_n: '1, data: '0,
                                  cclk: 1'b0, rdwr_n: 1'b0, urst: 1'b0};

    oreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            unique case (port)
                cfgp_pkg::PORT_PROG: begin
                    st_d.prog_n = wdata[NUM_FPGA-1:0];
                    st_d.cs_n   = wdata[2*NUM_FPGA-1:NUM_FPGA];
                end
                cfgp_pkg::PORT_DATA: st_d.data = wdata;
                cfgp_pkg::PORT_CTRL: begin
                    st_d.cclk   = wdata[0];
                    st_d.rdwr_n = wdata[1];
                    st_d.urst   = wdata[2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RST_VAL;
        else        st_q <= st_d;
    end

    assign prog_n     = st_q.prog_n;
    assign cs_n       = st_q.cs_n;
    assign cfg_byte   = st_q.data;
    assign cfg_clk    = st_q.cclk;
    assign cfg_rdwr_n = st_q.rdwr_n;
    assign user_rst   = st_q.urst;

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(st_q));

    // R8
    stat_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && port == cfgp_pkg::PORT_STAT) |=> $stable(st_q));

endmodule

// File: rtl/cfgp_slave.sv
module cfgp_slave #(
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 8,
    parameter int SLOT_W   = 5,
    parameter int NUM_FPGA = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SLOT_W-1:0]   slot_id,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic                bus_strobe,
    output logic                bus_ack,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic [NUM_FPGA-1:0] fpga_prog_n,
    output logic [NUM_FPGA-1:0] fpga_cs_n,
    output logic [DATA_W-1:0]   cfg_byte,
    output logic                cfg_clk,
    output logic                cfg_rdwr_n,
    output logic                user_rst,
    input  logic                fpga_busy,
    input  logic                fpga_done,
    input  logic                fpga_init_n
);
    logic            hit;
    cfgp_pkg::port_e port;
    logic [DATA_W-1:0] rval;

    cfgp_decode #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_dec (
        .addr    (bus_addr),
        .slot_id (slot_id),
        .hit     (hit),
        .port    (port)
    );

    cfgp_readback #(.DATA_W(DATA_W)) u_rb (
        .port   (port),
        .busy   (fpga_busy),
        .done   (fpga_done),
        .init_n (fpga_init_n),
        .rval   (rval)
    );

    typedef struct packed {
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } hs_t;

    hs_t  hs_d, hs_q;
    logic accept;
    logic wr_en;

    always_comb begin
        hs_d   = hs_q;
        accept = bus_strobe && hit && !hs_q.ack;
        wr_en  = accept && bus_we;
        if (accept) begin
            hs_d.ack   = 1'b1;
            hs_d.rdata = bus_we ? '0 : rval;
        end else if (!bus_strobe) begin
            hs_d.ack   = 1'b0;
            hs_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign bus_ack   = hs_q.ack;
    assign bus_rdata = hs_q.rdata;

    cfgp_outregs #(.DATA_W(DATA_W), .NUM_FPGA(NUM_FPGA)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .port       (port),
        .wdata      (bus_wdata),
        .prog_n     (fpga_prog_n),
        .cs_n       (fpga_cs_n),
        .cfg_byte   (cfg_byte),
        .cfg_clk    (cfg_clk),
        .cfg_rdwr_n (cfg_rdwr_n),
        .user_rst   (user_rst)
    );

    // R10
    ack_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ack) |-> $past(bus_strobe));

    // R10
    ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_strobe) |=> bus_ack);

    // R10
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_strobe |=> !bus_ack);

    // R10
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdata == '0));

    // R7
    rdata_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:3] == '0);

    // R2
    rsv_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_id == SLOT_W'(1) && !bus_ack) |=> !bus_ack);

endmodule

// File: tb/cfgp_slave_test.sv
module cfgp_slave_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  slot_id = 5'd11;
    logic [23:0] bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_strobe = 1'b0;
    logic        bus_ack;
    logic [7:0]  bus_rdata;
    logic [3:0]  fpga_prog_n, fpga_cs_n;
    logic [7:0]  cfg_byte;
    logic        cfg_clk, cfg_rdwr_n, user_rst;
    logic        fpga_busy = 1'b0, fpga_done = 1'b0, fpga_init_n = 1'b0;

    always #10 clk = ~clk;

    cfgp_slave uut (
        .clk(clk), .rst_n(rst_n), .slot_id(slot_id), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_strobe(bus_strobe),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .fpga_prog_n(fpga_prog_n),
        .fpga_cs_n(fpga_cs_n), .cfg_byte(cfg_byte), .cfg_clk(cfg_clk),
        .cfg_rdwr_n(cfg_rdwr_n), .user_rst(user_rst), .fpga_busy(fpga_busy),
        .fpga_done(fpga_done), .fpga_init_n(fpga_init_n)
    );

    int n_run = 0;
    int n_fail = 0;

    typedef struct {
        string      tag;
        logic [7:0] rdata;
        logic [26:0] pins;
    } exp_t;

    exp_t exp_q[$];

    logic [3:0] m_prog_n = 4'hF, m_cs_n = 4'hF;
    logic [7:0] m_byte = 8'h00;
    logic [2:0] m_ctrl = 3'b000;

    function automatic logic [26:0] model_pins();
        return {m_prog_n, m_cs_n, m_byte, m_ctrl[0], m_ctrl[1], m_ctrl[2], 8'h00};
    endfunction

    function automatic logic [26:0] dut_pins();
        return {fpga_prog_n, fpga_cs_n, cfg_byte, cfg_clk, cfg_rdwr_n, user_rst, 8'h00};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // R1: slot field order in address bits 16..20 is slot bits 3,4,0,1,2
    function automatic logic [23:0] mk_addr(input logic a23, input logic [1:0] win,
                                            input logic [4:0] slot, input logic [1:0] prt,
                                            input logic [13:0] low);
        logic [4:0] f;
        f = {slot[2], slot[1], slot[0], slot[4], slot[3]};
        return {a23, win, f, prt, low};
    endfunction

    // Monitor: pops one expected item on each rising acknowledge.
    logic prev_ack = 1'b0;
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack && !prev_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected ack", 32'(bus_ack), 32'd0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(bus_rdata == e.rdata, {e.tag, " rdata"}, 32'(bus_rdata), 32'(e.rdata));
                    check(dut_pins() == e.pins, {e.tag, " pins"}, 32'(dut_pins()), 32'(e.pins));
                end
            end
            prev_ack = bus_ack;
        end
    end

    // Driver for matching accesses; the model is updated from the requirements.
    task automatic access(input string tag, input logic [23:0] a, input logic we,
                          input logic [7:0] wd, input int hold);
        exp_t e;
        logic [1:0] prt;
        prt = a[15:14];
        e.tag = tag;
        e.rdata = 8'h00;
        if (we) begin
            case (prt)
                2'd0: begin m_prog_n = wd[3:0]; m_cs_n = wd[7:4]; end
                2'd1: m_byte = wd;
                2'd2: m_ctrl = wd[2:0];
                default: ;
            endcase
        end else if (prt == 2'd3) begin
            e.rdata = {5'b0, fpga_init_n, fpga_done, fpga_busy};
        end
        e.pins = model_pins();
        exp_q.push_back(e);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; bus_strobe = 1'b1;
        @(negedge clk);
        check(bus_ack == 1'b1, {tag, " R10 ack after one clock"}, 32'(bus_ack), 32'd1);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(bus_ack == 1'b1, {tag, " R10 ack held"}, 32'(bus_ack), 32'd1);
        end
        bus_strobe = 1'b0;
        @(negedge clk);
        check(bus_ack == 1'b0, {tag, " R10 ack drop"}, 32'(bus_ack), 32'd0);
        check(bus_rdata == 8'h00, {tag, " R10 rdata idle"}, 32'(bus_rdata), 32'd0);
        check(dut_pins() == model_pins(), {tag, " pins after"}, 32'(dut_pins()), 32'(model_pins()));
    endtask

    // Strobe that must not be acknowledged and must leave the pins alone.
    task automatic miss(input string tag, input logic [23:0] a, input logic we, input logic [7:0] wd);
        @(negedge clk);
        bus_addr = a; bus_we = we; bus_wdata = wd; bus_strobe = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(bus_ack == 1'b0, {tag, " no ack"}, 32'(bus_ack), 32'd0);
        end
        bus_strobe = 1'b0;
        @(negedge clk);
        check(dut_pins() == model_pins(), {tag, " pins unchanged"}, 32'(dut_pins()), 32'(model_pins()));
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check(dut_pins() == model_pins(), "R9 reset pins", 32'(dut_pins()), 32'(model_pins()));
        check(bus_ack == 1'b0, "R9 reset ack", 32'(bus_ack), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(dut_pins() == model_pins(), "R9 pins after release", 32'(dut_pins()), 32'(model_pins()));

        // R4 program/select port
        access("R4 prog/cs", mk_addr(1'b0, 2'b11, 5'd11, 2'd0, 14'h0000), 1'b1, 8'hA5, 0);
        // R5 and R3 alias: low bits all ones
        access("R5 R3 data alias", mk_addr(1'b0, 2'b11, 5'd11, 2'd1, 14'h3FFF), 1'b1, 8'h3C, 0);
        // R6 control, then reserved bit only
        access("R6 ctrl all", mk_addr(1'b0, 2'b11, 5'd11, 2'd2, 14'h1234), 1'b1, 8'hFF, 0);
        access("R6 ctrl reserved", mk_addr(1'b0, 2'b11, 5'd11, 2'd2, 14'h0001), 1'b1, 8'hF8, 0);
        access("R6 ctrl clk", mk_addr(1'b0, 2'b11, 5'd11, 2'd2, 14'h0002), 1'b1, 8'h01, 0);
        // R7 status read, with A23 set (R1)
        fpga_busy = 1'b1; fpga_done = 1'b0; fpga_init_n = 1'b1;
        access("R7 R1 status a23", mk_addr(1'b1, 2'b11, 5'd11, 2'd3, 14'h2AAA), 1'b0, 8'h00, 0);
        fpga_busy = 1'b0; fpga_done = 1'b1; fpga_init_n = 1'b0;
        access("R7 status", mk_addr(1'b0, 2'b11, 5'd11, 2'd3, 14'h0000), 1'b0, 8'h00, 0);
        // R8 write to status, read of write-only ports
        access("R8 status write", mk_addr(1'b0, 2'b11, 5'd11, 2'd3, 14'h0010), 1'b1, 8'hFF, 0);
        access("R8 read prog", mk_addr(1'b0, 2'b11, 5'd11, 2'd0, 14'h0000), 1'b0, 8'h00, 0);
        access("R8 read data", mk_addr(1'b0, 2'b11, 5'd11, 2'd1, 14'h0000), 1'b0, 8'h00, 0);
        // R10 long strobe: one access, ack held
        access("R10 long strobe", mk_addr(1'b0, 2'b11, 5'd11, 2'd1, 14'h0100), 1'b1, 8'h5A, 5);
        // R1 misses: wrong window tag, wrong slot, slot swapped bits
        miss("R1 window tag", mk_addr(1'b0, 2'b10, 5'd11, 2'd1, 14'h0), 1'b1, 8'h11);
        miss("R1 window low", mk_addr(1'b1, 2'b01, 5'd11, 2'd0, 14'h0), 1'b1, 8'h00);
        miss("R1 other slot", mk_addr(1'b0, 2'b11, 5'd12, 2'd1, 14'h0), 1'b1, 8'h22);
        miss("R1 unscrambled", {3'b011, 5'd11, 2'd1, 14'h0}, 1'b1, 8'h33);
        // R1 sweep of legal slots
        for (int s = 2; s <= 21; s++) begin
            slot_id = 5'(s);
            access("R1 slot sweep", mk_addr(s[0], 2'b11, 5'(s), 2'd1, 14'(s * 37)), 1'b1, 8'(s + 8'h40), 0);
        end
        // R2 reserved slot
        slot_id = 5'd1;
        miss("R2 slot 1 write", mk_addr(1'b0, 2'b11, 5'd1, 2'd1, 14'h0), 1'b1, 8'h77);
        miss("R2 slot 1 read", mk_addr(1'b0, 2'b11, 5'd1, 2'd3, 14'h0), 1'b0, 8'h00);
        slot_id = 5'd11;
        // R9 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        m_prog_n = 4'hF; m_cs_n = 4'hF; m_byte = 8'h00; m_ctrl = 3'b000;
        @(negedge clk);
        check(dut_pins() == model_pins(), "R9 reset again", 32'(dut_pins()), 32'(model_pins()));
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R10 all acks seen", 32'(exp_q.size()), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule